// File: doc/BRIEF.md
# Link Transmit Arbiter with Timed Insertion

This block produces the outgoing character stream of a serial link, one character per clock. Each character is a 16-bit word plus a 2-bit kind field. The kind field marks the word either as plain data or as a special (link-level) character. Two frame sources, bulk and control, offer payload words over valid/ready. The arbiter wraps each frame in an opening marker, the payload, a CRC-16 word and a closing marker. When no frame is in progress and nothing is offered, it fills the link with idle characters.

A third input is the timing request. It is a single-cycle strobe with a 16-bit message. It has absolute priority. Two cycles after the request cycle, a sync character leaves the block, followed at once by the message word. This happens in every state, including the middle of a frame. The interrupted frame then continues with exactly the character it would have sent next. The CRC ignores the inserted characters. While the two characters are inserted, both payload readies stay low, so the sources see back-pressure rather than lost words.

Back-pressure rules: a payload word transfers on a rising edge where valid and ready are both high. Ready is only ever high for the granted source, only in the payload phase, and never in an insertion cycle. A source may drop valid inside a frame. Idle characters then fill the stall and the frame resumes when valid returns. The word with `last` high ends the payload. Payload length (4 to 32 words) is the source's responsibility.

Top module: `lnk_tx_arbiter`

## Requirements
- R1: On reset, and while reset is held, the output is the idle special character (kind 2'b11, word 16'h1C1C) and both payload readies are low.
- R2: With no frame in progress, nothing offered and no timing request, every output character is idle (kind 2'b11, word 16'h1C1C).
- R3: A bulk frame is sent as: opening special 16'h3C3C, the payload words in order as data (kind 2'b00), the CRC word as data, then the closing special 16'h7C7C.
- R4: A control frame has the same layout but opens with special 16'h5C5C.
- R5: When both sources are valid at a frame boundary, the control frame is granted first and the bulk frame follows it.
- R6: The CRC word is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, fed MSB first over the payload words only.
- R7: A timing request sampled high in cycle n yields the sync special 16'h9C9C on the output in cycle n+2 and the message word as data in cycle n+3, whatever the frame state.
- R8: After an insertion, the interrupted frame continues with its next character unchanged, and the inserted characters do not enter the CRC.
- R9: A payload ready is high only for the granted source during its payload phase. Both readies are low in the two cycles in which the sync and message characters are selected.
- R10: A timing request in the cycle directly after an accepted one is ignored and produces no extra sync character. A request two cycles after is accepted.
- R11: When the granted source drops valid during the payload, idle characters fill the gap and the frame resumes with its next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bulk_valid | input | 1 | Bulk payload word valid |
| bulk_ready | output | 1 | Bulk payload word accepted |
| bulk_word | input | 16 | Bulk payload word |
| bulk_last | input | 1 | Final word of the bulk frame |
| ctrl_valid | input | 1 | Control payload word valid |
| ctrl_ready | output | 1 | Control payload word accepted |
| ctrl_word | input | 16 | Control payload word |
| ctrl_last | input | 1 | Final word of the control frame |
| tm_req | input | 1 | Timing message request strobe |
| tm_msg | input | 16 | Timing message word |
| tx_word | output | 16 | Outgoing character word |
| tx_ctl | output | 2 | Character kind: 2'b00 data, 2'b11 special |

## Verification
Some faults hide in internal state: a frame state machine that fails to freeze during an insertion, or a CRC register that absorbs an inserted word. Such a fault shows at the ports as a skipped, repeated or wrong character. It appears within one or two cycles of the sync character, or at the latest in the CRC word at frame end. A wrong insertion pipeline shows as a sync character one cycle early or late relative to the request cycle, so the checks pin the exact cycle. A wrong grant or ready shows as a frame opened with the wrong marker, or as payload words taken from the wrong source.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int WORD_W = 16;
  localparam int CTL_W  = 2;
  localparam int NSRC   = 2;
  localparam int SRC_BULK = 0;
  localparam int SRC_CTRL = 1;

  localparam logic [CTL_W-1:0] KIND_DATA = 2'b00;
  localparam logic [CTL_W-1:0] KIND_SPEC = 2'b11;

  localparam logic [WORD_W-1:0] SP_IDLE = 16'h1C1C;
  localparam logic [WORD_W-1:0] SP_OPEN_BULK = 16'h3C3C;
  localparam logic [WORD_W-1:0] SP_OPEN_CTRL = 16'h5C5C;
  localparam logic [WORD_W-1:0] SP_CLOSE = 16'h7C7C;
  localparam logic [WORD_W-1:0] SP_SYNC = 16'h9C9C;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_PAY,
    FR_CRC,
    FR_CLOSE
  } fr_state_t;
endpackage

// File: rtl/lnk_tx_crc.sv
module lnk_tx_crc
  import lnk_tx_pkg::*;
#(
  parameter logic [WORD_W-1:0] POLY = 16'h1021,
  parameter logic [WORD_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              update,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc
);
  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = c;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (r[WORD_W-1] ^ d[b]) r = (r << 1) ^ POLY;
      else                    r = r << 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= SEED;
    else if (clear)  crc <= SEED;
    else if (update) crc <= crc_step(crc, word);
  end

  // R6
  clear_update_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && update));
endmodule

// File: rtl/lnk_tx_timing.sv
module lnk_tx_timing
  import lnk_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tm_req,
  input  logic [WORD_W-1:0] tm_msg,
  output logic              accept,
  output logic              sync_slot,
  output logic              msg_slot,
  output logic              busy,
  output logic [WORD_W-1:0] msg_q
);
  logic pend_q, ph2_q;

  // a request is taken unless the previous cycle already took one
  assign accept    = tm_req && !pend_q;
  assign sync_slot = pend_q;
  assign msg_slot  = ph2_q;
  assign busy      = pend_q || ph2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ph2_q  <= 1'b0;
      msg_q  <= '0;
    end else begin
      pend_q <= accept;
      ph2_q  <= pend_q;
      if (accept) msg_q <= tm_msg;
    end
  end

  // R7
  sync_then_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_slot |=> msg_slot);

  // R10
  no_slot_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_slot && msg_slot));
endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
  import lnk_tx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hold,
  input  logic [NSRC-1:0]               src_valid,
  input  logic [NSRC-1:0]               src_last,
  input  logic [NSRC-1:0][WORD_W-1:0]   src_word,
  output logic [NSRC-1:0]               src_ready,
  input  logic [WORD_W-1:0]             crc_val,
  output logic                          crc_clear,
  output logic                          crc_upd,
  output logic [WORD_W-1:0]             pay_word,
  output logic [WORD_W-1:0]             nxt_word,
  output logic [CTL_W-1:0]              nxt_ctl
);
  fr_state_t state_q, state_d;
  logic      sel_q, sel_d;
  logic      cur_valid, cur_last, start;

  assign cur_valid = src_valid[sel_q];
  assign cur_last  = src_last[sel_q];
  assign pay_word  = src_word[sel_q];

  for (genvar i = 0; i < NSRC; i++) begin : g_ready
    assign src_ready[i] = (state_q == FR_PAY) && (sel_q == 1'(i)) && !hold;
  end

  assign crc_upd   = |(src_ready & src_valid);
  assign start     = (state_q == FR_IDLE) && !hold && (|src_valid);
  assign crc_clear = start;

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    nxt_word = SP_IDLE;
    nxt_ctl  = KIND_SPEC;
    if (!hold) begin
      unique case (state_q)
        FR_IDLE: begin
          if (src_valid[SRC_CTRL]) begin
            sel_d    = 1'b1;
            nxt_word = SP_OPEN_CTRL;
            state_d  = FR_PAY;
          end else if (src_valid[SRC_BULK]) begin
            sel_d    = 1'b0;
            nxt_word = SP_OPEN_BULK;
            state_d  = FR_PAY;
          end
        end
        FR_PAY: begin
          if (cur_valid) begin
            nxt_word = pay_word;
            nxt_ctl  = KIND_DATA;
            if (cur_last) state_d = FR_CRC;
          end
        end
        FR_CRC: begin
          nxt_word = crc_val;
          nxt_ctl  = KIND_DATA;
          state_d  = FR_CLOSE;
        end
        FR_CLOSE: begin
          nxt_word = SP_CLOSE;
          state_d  = FR_IDLE;
        end
        default: state_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  // R9
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready));

  // R3
  crc_to_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_CRC && !hold) |=> (state_q == FR_CLOSE));

  // R8
  hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(state_q) && $stable(sel_q));
endmodule

// File: rtl/lnk_tx_arbiter.sv
module lnk_tx_arbiter
  import lnk_tx_pkg::*;
#(
  parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [WORD_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bulk_valid,
  output logic              bulk_ready,
  input  logic [WORD_W-1:0] bulk_word,
  input  logic              bulk_last,
  input  logic              ctrl_valid,
  output logic              ctrl_ready,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic              ctrl_last,
  input  logic              tm_req,
  input  logic [WORD_W-1:0] tm_msg,
  output logic [WORD_W-1:0] tx_word,
  output logic [CTL_W-1:0]  tx_ctl
);
  logic                        accept, sync_slot, msg_slot, busy;
  logic [WORD_W-1:0]           msg_q, crc_val, pay_word, nxt_word;
  logic [CTL_W-1:0]            nxt_ctl;
  logic                        crc_clear, crc_upd;
  logic [NSRC-1:0]             src_valid, src_last, src_ready;
  logic [NSRC-1:0][WORD_W-1:0] src_word;

  assign src_valid[SRC_BULK] = bulk_valid;
  assign src_valid[SRC_CTRL] = ctrl_valid;
  assign src_last[SRC_BULK]  = bulk_last;
  assign src_last[SRC_CTRL]  = ctrl_last;
  assign src_word[SRC_BULK]  = bulk_word;
  assign src_word[SRC_CTRL]  = ctrl_word;
  assign bulk_ready          = src_ready[SRC_BULK];
  assign ctrl_ready          = src_ready[SRC_CTRL];

  lnk_tx_timing u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .tm_req    (tm_req),
    .tm_msg    (tm_msg),
    .accept    (accept),
    .sync_slot (sync_slot),
    .msg_slot  (msg_slot),
    .busy      (busy),
    .msg_q     (msg_q)
  );

  lnk_tx_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (busy),
    .src_valid (src_valid),
    .src_last  (src_last),
    .src_word  (src_word),
    .src_ready (src_ready),
    .crc_val   (crc_val),
    .crc_clear (crc_clear),
    .crc_upd   (crc_upd),
    .pay_word  (pay_word),
    .nxt_word  (nxt_word),
    .nxt_ctl   (nxt_ctl)
  );

  lnk_tx_crc #(
    .POLY (CRC_POLY),
    .SEED (CRC_SEED)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (crc_clear),
    .update (crc_upd),
    .word   (pay_word),
    .crc    (crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= SP_IDLE;
      tx_ctl  <= KIND_SPEC;
    end else if (sync_slot) begin
      tx_word <= SP_SYNC;
      tx_ctl  <= KIND_SPEC;
    end else if (msg_slot) begin
      tx_word <= msg_q;
      tx_ctl  <= KIND_DATA;
    end else begin
      tx_word <= nxt_word;
      tx_ctl  <= nxt_ctl;
    end
  end

  // R7
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 (tx_ctl == KIND_SPEC && tx_word == SP_SYNC));

  // R7
  msg_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ctl == KIND_SPEC && tx_word == SP_SYNC) |=> (tx_ctl == KIND_DATA));

  // R9
  ready_low_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_slot || msg_slot) |-> !(bulk_ready || ctrl_ready));
endmodule

// File: tb/test_lnk_tx_arbiter.sv
`timescale 1ns/1ps
module test_lnk_tx_arbiter;
  import lnk_tx_pkg::*;

  localparam int MAXC = 300;
  localparam int MAXE = 80;
  localparam int NSCN = 8;
  // {n_ctrl, n_bulk, tm1, tm2, gap, seed}; 8'hFF = no request
  localparam logic [55:0] SCN [NSCN] = '{
    {8'd0, 8'd4,  8'hFF, 8'hFF, 8'd0, 16'h1000},
    {8'd4, 8'd0,  8'hFF, 8'hFF, 8'd0, 16'h2000},
    {8'd0, 8'd32, 8'd5,  8'hFF, 8'd0, 16'h3000},
    {8'd5, 8'd6,  8'd0,  8'hFF, 8'd0, 16'h4000},
    {8'd0, 8'd4,  8'd5,  8'hFF, 8'd0, 16'h5000},
    {8'd0, 8'd6,  8'd4,  8'd5,  8'd3, 16'h6000},
    {8'd0, 8'd0,  8'd2,  8'd4,  8'd0, 16'h7000},
    {8'd6, 8'd5,  8'd9,  8'd14, 8'd4, 16'h8000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bulk_valid = 1'b0, bulk_last = 1'b0, ctrl_valid = 1'b0, ctrl_last = 1'b0;
  logic tm_req = 1'b0;
  logic [15:0] bulk_word = '0, ctrl_word = '0, tm_msg = '0;
  logic bulk_ready, ctrl_ready;
  logic [15:0] tx_word;
  logic [1:0]  tx_ctl;

  int checks = 0;
  int errors = 0;

  logic [15:0] rw [MAXC];
  logic [1:0]  rc [MAXC];
  logic        rrb [MAXC];
  logic        rrc [MAXC];
  bit          skip [MAXC];
  logic [15:0] ew [MAXE];
  logic [1:0]  ec [MAXE];

  always #2 clk = ~clk;

  lnk_tx_arbiter i_lnk_tx_arbiter (
    .clk(clk), .rst_n(rst_n),
    .bulk_valid(bulk_valid), .bulk_ready(bulk_ready), .bulk_word(bulk_word), .bulk_last(bulk_last),
    .ctrl_valid(ctrl_valid), .ctrl_ready(ctrl_ready), .ctrl_word(ctrl_word), .ctrl_last(ctrl_last),
    .tm_req(tm_req), .tm_msg(tm_msg), .tx_word(tx_word), .tx_ctl(tx_ctl)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] gen(input logic [15:0] s, input int src, input int i);
    return s ^ 16'(src * 16'h0F0F) ^ 16'(i * 16'h1357 + i);
  endfunction

  // R6: CRC-16, poly 0x1021, start 0xFFFF, MSB first, payload only
  function automatic logic [15:0] ref_crc(input logic [15:0] s, input int src, input int n);
    logic [15:0] c;
    logic [15:0] w;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      w = gen(s, src, i);
      for (int b = 15; b >= 0; b--) begin
        fb = c[15] ^ w[b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic run_scn(input int nctl, input int nblk, input int tm1, input int tm2,
                         input int gap, input logic [15:0] seed);
    int cyc, ci, bi, eofs, nfr, lastreq, nexp, j, nsync, nacc;
    bit hs_c, hs_b, stall, a1, a2, ok, fin;
    logic [15:0] m1, m2;
    string tag;
    logic [31:0] act_v, exp_v;
    cyc = 0; ci = 0; bi = 0; eofs = 0; hs_c = 0; hs_b = 0; fin = 0;
    nfr = (nctl > 0 ? 1 : 0) + (nblk > 0 ? 1 : 0);
    lastreq = 0;
    if (tm1 != 255 && tm1 > lastreq) lastreq = tm1;
    if (tm2 != 255 && tm2 > lastreq) lastreq = tm2;
    m1 = seed ^ 16'hC3A5;
    m2 = seed ^ 16'h5A3C;
    for (int k = 0; k < MAXC; k++) skip[k] = 0;
    while (!fin && cyc < MAXC) begin
      @(negedge clk);
      rw[cyc] = tx_word; rc[cyc] = tx_ctl;
      rrb[cyc] = bulk_ready; rrc[cyc] = ctrl_ready;
      if (hs_c) ci++;
      if (hs_b) bi++;
      if (tx_ctl == KIND_SPEC && tx_word == SP_CLOSE) eofs++;
      stall = (gap != 0) && (cyc % gap == 0);
      ctrl_valid = (ci < nctl) && !stall;
      ctrl_word  = gen(seed, 1, ci);
      ctrl_last  = (ci == nctl - 1);
      bulk_valid = (bi < nblk) && !stall;
      bulk_word  = gen(seed, 0, bi);
      bulk_last  = (bi == nblk - 1);
      tm_req = (cyc == tm1) || (cyc == tm2);
      tm_msg = (cyc == tm2) ? m2 : m1;
      hs_c = ctrl_valid && ctrl_ready;
      hs_b = bulk_valid && bulk_ready;
      if (ci >= nctl && bi >= nblk && eofs == nfr && cyc > lastreq + 4) fin = 1;
      cyc++;
    end
    ctrl_valid = 0; bulk_valid = 0; tm_req = 0;
    chk(fin, "R3", "scenario completion", 32'(cyc), 32'(MAXC));
    if (!fin) return;

    a1 = (tm1 != 255);
    a2 = (tm2 != 255) && !(a1 && tm2 == tm1 + 1);
    nacc = (a1 ? 1 : 0) + (a2 ? 1 : 0);
    for (int q = 0; q < 2; q++) begin
      int t;
      logic [15:0] m;
      if (q == 0 && !a1) continue;
      if (q == 1 && !a2) continue;
      t = (q == 0) ? tm1 : tm2;
      m = (q == 0) ? m1 : m2;
      // R7: sync two cycles after the request, message next
      chk(rc[t+2] == KIND_SPEC && rw[t+2] == SP_SYNC, "R7", "sync position",
          {14'd0, rc[t+2], rw[t+2]}, {14'd0, KIND_SPEC, SP_SYNC});
      chk(rc[t+3] == KIND_DATA && rw[t+3] == m, "R7", "message word",
          {14'd0, rc[t+3], rw[t+3]}, {14'd0, KIND_DATA, m});
      // R9: readies low while inserting
      chk(!rrb[t+1] && !rrc[t+1] && !rrb[t+2] && !rrc[t+2], "R9", "ready during insert",
          {28'd0, rrb[t+1], rrc[t+1], rrb[t+2], rrc[t+2]}, 32'd0);
      skip[t+2] = 1; skip[t+3] = 1;
    end
    // R10: only accepted requests produce a sync
    nsync = 0;
    for (int k = 0; k < cyc; k++)
      if (rc[k] == KIND_SPEC && rw[k] == SP_SYNC) nsync++;
    chk(nsync == nacc, "R10", "sync count", 32'(nsync), 32'(nacc));
    // R9: never both readies
    ok = 1;
    for (int k = 0; k < cyc; k++) if (rrb[k] && rrc[k]) ok = 0;
    chk(ok, "R9", "both readies high", 32'(ok), 32'd1);

    // expected frames: control first (R4, R5), then bulk (R3), CRC per R6
    nexp = 0;
    if (nctl > 0) begin
      ec[nexp] = KIND_SPEC; ew[nexp] = SP_OPEN_CTRL; nexp++;
      for (int i = 0; i < nctl; i++) begin ec[nexp] = KIND_DATA; ew[nexp] = gen(seed, 1, i); nexp++; end
      ec[nexp] = KIND_DATA; ew[nexp] = ref_crc(seed, 1, nctl); nexp++;
      ec[nexp] = KIND_SPEC; ew[nexp] = SP_CLOSE; nexp++;
    end
    if (nblk > 0) begin
      ec[nexp] = KIND_SPEC; ew[nexp] = SP_OPEN_BULK; nexp++;
      for (int i = 0; i < nblk; i++) begin ec[nexp] = KIND_DATA; ew[nexp] = gen(seed, 0, i); nexp++; end
      ec[nexp] = KIND_DATA; ew[nexp] = ref_crc(seed, 0, nblk); nexp++;
      ec[nexp] = KIND_SPEC; ew[nexp] = SP_CLOSE; nexp++;
    end
    // idle fill (R2, R11) is dropped; interrupted frames must resume intact (R8)
    tag = (nctl > 0 && nblk > 0) ? "R5 R4 R3 R6" : (nctl > 0 ? "R4 R6" : "R3 R6");
    if (nacc > 0) tag = {tag, " R8"};
    if (gap != 0) tag = {tag, " R11"};
    ok = 1; j = 0; act_v = '0; exp_v = '0;
    for (int k = 0; k < cyc; k++) begin
      if (skip[k]) continue;
      if (rc[k] == KIND_SPEC && rw[k] == SP_IDLE) continue;
      if (ok) begin
        if (j >= nexp) begin
          ok = 0; act_v = {14'd0, rc[k], rw[k]}; exp_v = 32'hFFFF_FFFF;
        end else if (rc[k] != ec[j] || rw[k] != ew[j]) begin
          ok = 0; act_v = {14'd0, rc[k], rw[k]}; exp_v = {14'd0, ec[j], ew[j]};
        end
      end
      j++;
    end
    if (ok && j != nexp) begin ok = 0; act_v = 32'(j); exp_v = 32'(nexp); end
    chk(ok, tag, "character stream", act_v, exp_v);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_ctl == KIND_SPEC && tx_word == SP_IDLE, "R1", "output in reset",
        {14'd0, tx_ctl, tx_word}, {14'd0, KIND_SPEC, SP_IDLE});
    chk(!bulk_ready && !ctrl_ready, "R1", "readies in reset",
        {30'd0, bulk_ready, ctrl_ready}, 32'd0);
    rst_n = 1'b1;
    // R2: idle fill with nothing pending
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(tx_ctl == KIND_SPEC && tx_word == SP_IDLE, "R2", "idle fill",
          {14'd0, tx_ctl, tx_word}, {14'd0, KIND_SPEC, SP_IDLE});
    end

    for (int s = 0; s < NSCN; s++) begin
      run_scn(int'(SCN[s][55:48]), int'(SCN[s][47:40]), int'(SCN[s][39:32]),
              int'(SCN[s][31:24]), int'(SCN[s][23:16]), SCN[s][15:0]);
      repeat (3) @(negedge clk);
    end

    // R1: reset applied in the middle of a frame
    bulk_valid = 1'b1; bulk_word = 16'hABCD; bulk_last = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(tx_ctl == KIND_SPEC && tx_word == SP_IDLE, "R1", "output after mid-frame reset",
        {14'd0, tx_ctl, tx_word}, {14'd0, KIND_SPEC, SP_IDLE});
    chk(!bulk_ready && !ctrl_ready, "R1", "readies after mid-frame reset",
        {30'd0, bulk_ready, ctrl_ready}, 32'd0);
    @(negedge clk);
    bulk_valid = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_ctl == KIND_SPEC && tx_word == SP_IDLE, "R2", "idle after reset release",
          {14'd0, tx_ctl, tx_word}, {14'd0, KIND_SPEC, SP_IDLE});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule